// File: doc/BRIEF.md
# Rotate-and-Masked-Insert Unit

This execution datapath splices bits from a 32-bit source word into the old value of a destination word. It has two operations. The masked merge rotates the source left by a variable amount. It then keeps the rotated bits that fall inside a mask set by a begin position and an end position, and takes every other bit from the destination. The single-bit insert copies the most significant bit of the source into one chosen bit position of the destination and leaves the other 31 destination bits unchanged.

Bit positions for the mask and for the insert are counted from the most significant bit, which is position 0. The mask may wrap around the end of the word. When the record flag is set, a 4-bit condition field is loaded from the final result word. The result can be registered (the default) or combinational. The condition field is always held in a register.

Top module: `rot_merge_unit`

## Requirements
- R1: Only the low 5 bits of `amt_i` set the rotate or insert amount n. All higher bits of `amt_i` have no effect on the result.
- R2: With `op_i`=0 (masked merge), the result is (rotl(src_i, n) AND mask) OR (dst_i AND NOT mask).
- R3: Mask bit positions are numbered with position 0 as the MSB (bit 31) and position 31 as the LSB (bit 0). When `mb_i` <= `me_i`, the mask covers positions `mb_i` through `me_i`. This includes the single-position case `mb_i` = `me_i`.
- R4: When `mb_i` > `me_i`, the mask wraps. It covers positions `mb_i` through 31 and positions 0 through `me_i`.
- R5: With `op_i`=1 (bit insert), `src_i[31]` is written to position n (bit index 31-n). Every other bit is taken from `dst_i`.
- R6: When `rec_i`=1, `cr_o` is loaded from the final result word on the same edge as the result: bit 3 = result negative (signed), bit 2 = result positive, bit 1 = result zero, bit 0 = `so_i`.
- R7: When `rec_i`=0, `cr_o` keeps its previous value.
- R8: With `OUT_REG`=1, `res_o` shows the result one clock edge after the operands are applied. While `rst_ni` is low, `res_o` and `cr_o` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| op_i | input | 1 | 0 = masked merge, 1 = single-bit insert |
| src_i | input | 32 | Source word |
| dst_i | input | 32 | Old destination word |
| amt_i | input | 32 | Amount word; only the low 5 bits are used |
| mb_i | input | 5 | Mask begin position (MSB-first) |
| me_i | input | 5 | Mask end position (MSB-first) |
| rec_i | input | 1 | Record flag: load the condition field |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| res_o | output | 32 | Result word |
| cr_o | output | 4 | Condition field |

## Verification
Both `res_o` and `cr_o` are due one rising edge after the operands are applied. The bench drives each operand set on a falling edge and samples both outputs on the next falling edge, after exactly one register stage. The hold requirement for the condition field is checked in that same sampling slot, on an operation issued with `rec_i` low. The reset state is read while reset is still asserted, after at least one edge.

// File: rtl/rot_merge_unit.sv
module rot_merge_unit #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_i,
  input  logic [W-1:0]         src_i,
  input  logic [W-1:0]         dst_i,
  input  logic [W-1:0]         amt_i,
  input  logic [$clog2(W)-1:0] mb_i,
  input  logic [$clog2(W)-1:0] me_i,
  input  logic                 rec_i,
  input  logic                 so_i,
  output logic [W-1:0]         res_o,
  output logic [3:0]           cr_o
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [SW-1:0]  n;
  logic [W-1:0]   mask, rotl, sel, merged, inserted, nxt;
  logic [2*W-1:0] dbl;
  logic [3:0]     cr_nxt;

  assign n   = amt_i[SW-1:0];
  assign dbl = {src_i, src_i} << n;
  assign rotl = dbl[2*W-1:W];

  always_comb begin
    for (int p = 0; p < W; p++) begin
      if (mb_i <= me_i)
        mask[W-1-p] = (p >= int'(mb_i)) && (p <= int'(me_i));
      else
        mask[W-1-p] = (p >= int'(mb_i)) || (p <= int'(me_i));
    end
  end

  assign sel      = TOP >> n;
  assign merged   = (rotl & mask) | (dst_i & ~mask);
  assign inserted = ((src_i >> n) & sel) | (dst_i & ~sel);
  assign nxt      = op_i ? inserted : merged;
  assign cr_nxt   = {$signed(nxt) < 0, $signed(nxt) > 0, nxt == '0, so_i};

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    cr_o <= '0;
    else if (rec_i) cr_o <= cr_nxt;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i) begin
        if (!rst_ni) res_o <= '0;
        else         res_o <= nxt;
      end

      // R6
      cr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_i |=> (cr_o[1] == (res_o == '0)));

      // R5
      ins_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i |=> (((res_o ^ $past(dst_i)) & ~(TOP >> $past(amt_i[SW-1:0]))) == '0));
    end else begin : g_comb
      assign res_o = nxt;
    end
  endgenerate

  // R6
  cr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> ($countones(cr_o[3:1]) == 1));

  // R6
  so_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (cr_o[0] == $past(so_i)));

  // R7
  cr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i |=> $stable(cr_o));
endmodule

// File: tb/rot_merge_unit_test.sv
module rot_merge_unit_test;
  localparam int PERIOD = 10;
  localparam int NV = 11;
  // {op, src, dst, amt, mb, me, expected}
  localparam logic [138:0] VEC [NV] = '{
    {1'b0, 32'h000000FF, 32'h00000000, 32'h00000000, 5'd0,  5'd31, 32'h000000FF},
    {1'b0, 32'h000000FF, 32'h12345678, 32'h00000008, 5'd16, 5'd23, 32'h1234FF78},
    {1'b0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 5'd28, 5'd3,  32'hF000000F},
    {1'b0, 32'h80000000, 32'h00000000, 32'h00000001, 5'd31, 5'd31, 32'h00000001},
    {1'b0, 32'hA5A5A5A5, 32'h00000000, 32'hFFFFFFE0, 5'd0,  5'd31, 32'hA5A5A5A5},
    {1'b0, 32'h00000002, 32'h00000000, 32'h0000001F, 5'd0,  5'd31, 32'h00000001},
    {1'b1, 32'h80000000, 32'h00000000, 32'h00000000, 5'd0,  5'd0,  32'h80000000},
    {1'b1, 32'h80000000, 32'h00000000, 32'h0000001F, 5'd0,  5'd0,  32'h00000001},
    {1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000004, 5'd0,  5'd0,  32'hF7FFFFFF},
    {1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000025, 5'd0,  5'd0,  32'h04000000},
    {1'b0, 32'h12345678, 32'h00000000, 32'h00000004, 5'd0,  5'd31, 32'h23456781}
  };
  localparam string VTAG [NV] = '{"R2", "R3", "R4", "R3", "R1", "R2",
                                  "R5", "R5", "R5", "R1", "R2"};

  logic clk = 0, rst_n = 0, op = 0, rec = 0, so = 0;
  logic [31:0] src = 0, dst = 0, amt = 0;
  logic [4:0] mb = 0, me = 0;
  logic [31:0] res;
  logic [3:0] cr;
  int checks = 0, fails = 0;

  rot_merge_unit uut (.clk_i(clk), .rst_ni(rst_n), .op_i(op), .src_i(src), .dst_i(dst),
    .amt_i(amt), .mb_i(mb), .me_i(me), .rec_i(rec), .so_i(so), .res_o(res), .cr_o(cr));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(logic o, logic [31:0] s, logic [31:0] d,
                                        logic [31:0] a, logic [4:0] b, logic [4:0] e);
    logic [31:0] r = d;
    int k = int'(a & 32'h1F);
    if (o) begin
      r[31-k] = s[31];
    end else begin
      for (int p = 0; p < 32; p++) begin
        bit in = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
        if (in) r[31-p] = s[(31 - p - k + 64) % 32];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(logic o, logic [31:0] s, logic [31:0] d, logic [31:0] a,
                     logic [4:0] b, logic [4:0] e, logic r, logic f);
    @(negedge clk);
    op = o; src = s; dst = d; amt = a; mb = b; me = e; rec = r; so = f;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] held;
    logic [31:0] e;
    op = 1; src = 32'hFFFFFFFF; dst = 32'hFFFFFFFF; rec = 1; so = 1;
    repeat (3) @(negedge clk);
    check("R8 reset res", res, 32'h0);
    check("R8 reset cr", {28'h0, cr}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][138], VEC[i][137:106], VEC[i][105:74], VEC[i][73:42],
          VEC[i][41:37], VEC[i][36:32], 1'b0, 1'b0);
      check({VTAG[i], " R8 vector"}, res, VEC[i][31:0]);
    end

    // R1: high amount bits ignored
    run(1'b0, 32'hCAFEBABE, 32'h0F0F0F0F, 32'hABCDE003, 5'd5, 5'd20, 1'b0, 1'b0);
    check("R1 amt high bits", res, model(1'b0, 32'hCAFEBABE, 32'h0F0F0F0F, 32'h3, 5'd5, 5'd20));

    // R6: negative, positive, zero, so copy
    run(1'b0, 32'h80000000, 32'h0, 32'h0, 5'd0, 5'd0, 1'b1, 1'b0);
    check("R6 cr neg", {28'h0, cr}, 32'h8);
    run(1'b0, 32'h00000001, 32'h0, 32'h0, 5'd31, 5'd31, 1'b1, 1'b1);
    check("R6 cr pos so", {28'h0, cr}, 32'h5);
    run(1'b1, 32'h00000000, 32'h0, 32'h0, 5'd0, 5'd0, 1'b1, 1'b0);
    check("R6 cr zero", {28'h0, cr}, 32'h2);
    run(1'b0, 32'h0, 32'h12345678, 32'h0, 5'd0, 5'd0, 1'b1, 1'b1);
    check("R6 cr final result", {28'h0, cr}, 32'h5);

    // R7: cr holds without record
    held = cr;
    run(1'b0, 32'h80000000, 32'h0, 32'h0, 5'd0, 5'd31, 1'b0, 1'b0);
    check("R7 cr hold", {28'h0, cr}, {28'h0, held});
    check("R7 res still updates", res, 32'h80000000);

    // R2 R4 R5 random against model
    for (int i = 0; i < 300; i++) begin
      logic o = 1'($urandom);
      logic [31:0] s = $urandom, d = $urandom, a = $urandom;
      logic [4:0] b = 5'($urandom), en = 5'($urandom);
      run(o, s, d, a, b, en, 1'b1, 1'b0);
      e = model(o, s, d, a, b, en);
      check(o ? "R5 random" : "R2 random", res, e);
      check("R6 random cr",
            {28'h0, cr}, {28'h0, $signed(e) < 0, $signed(e) > 0, e == 0, 1'b0});
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule